// File: doc/BRIEF.md
# Configurable Multi-Source I/O Port

This block is a general-purpose I/O port for a microcontroller peripheral. Each pin can drive one of four values: a bit of a data register written by the processor, a bit of the bus address held by an address latch, an output of a logic macrocell, or a chip-select line. The macrocell outputs, chip-select lines and external output-enable terms come from a programmable logic array outside this block, so they arrive here as plain inputs. Which value a pin drives, and whether its driver is enabled, is chosen for that pin alone. The choice comes from static configuration inputs and, on the full-featured variant, from a control register.

The processor reaches the port through a small register interface. It has a write strobe, a 3-bit register address and a read-data bus. A read returns exactly one source: the synchronized pin levels, the data register, the direction register, the control register or the macrocell outputs. The pad is modelled as three separate signals: a driven value, a driver enable and a sampled input level.

Top module: `mio_port`

## Requirements
- R1: A synchronous active-high reset clears the data, direction and control registers, and the two synchronizer stages. After reset, reads at addresses 1, 2 and 3 return zero. Every pin whose enable mode is "direction" has pin_oe low.
- R2: When wr_en is high at a rising clock edge, wr_data is loaded into the data register (address 1), the direction register (address 2) or the control register (address 3). From the next cycle, reading the same address returns the written value.
- R3: A write to address 0 (pin input), or to any address from 4 to 7, leaves the data, direction and control registers unchanged.
- R4: When control bit i is 0, pin i drives the source selected by cfg_sel[2i+1:2i]. The codes are 0 for the data register bit, 1 for the latched address bit, 2 for mc_out[i] and 3 for cs_in[i].
- R5: On the full-featured variant (HAS_CTRL=1), a control register bit of 1 makes that pin drive its latched address bit, whatever its cfg_sel code.
- R6: The address latch is transparent while ale is high and holds its last value while ale is low.
- R7: When cfg_oe_ext[i] is 0, pin_oe[i] equals direction bit i (1 = output). When cfg_oe_ext[i] is 1, pin_oe[i] follows oe_pt[i].
- R8: A read at address 0 returns pin_in through a two-stage synchronizer. A new level first appears after the second rising edge following its arrival.
- R9: A read at address 4 returns mc_out as it is at that moment. Reads at addresses 5 to 7 return zero.
- R10: When pin_oe[i] is low, pin_out[i] is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address for reads and writes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Read data of the selected source |
| ale | input | 1 | Address latch enable (transparent high) |
| bus_addr | input | WIDTH | Bus address bits presented to the latch |
| mc_out | input | WIDTH | Logic macrocell outputs, one per pin |
| cs_in | input | WIDTH | Chip-select lines, one per pin |
| oe_pt | input | WIDTH | External output-enable terms, one per pin |
| cfg_sel | input | 2*WIDTH | Static source code, two bits per pin |
| cfg_oe_ext | input | WIDTH | Per pin: 1 = enable from oe_pt, 0 = from direction register |
| pin_in | input | WIDTH | Level sampled at the pad |
| pin_out | output | WIDTH | Value driven onto the pad |
| pin_oe | output | WIDTH | Pad driver enable |

## Verification
A wrong register bit shows up within one cycle in two places. It appears in the read-back at its address, and on pin_out or pin_oe of the pin it controls. Sweeping every source code and control bit exposes a fault in the per-pin select the moment the inputs settle. A latch that leaks while ale is low shows as a changed pin value with no clock edge involved. A synchronizer with the wrong depth shows as read data that changes one cycle early or late against the two-edge schedule.

// File: rtl/mio_pkg.sv
package mio_pkg;

  typedef enum logic [1:0] {
    SRC_DOUT  = 2'd0,
    SRC_ADDR  = 2'd1,
    SRC_MCELL = 2'd2,
    SRC_CSEL  = 2'd3
  } src_e;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_PIN  = 3'd0;
  localparam logic [REG_AW-1:0] RA_DOUT = 3'd1;
  localparam logic [REG_AW-1:0] RA_DIR  = 3'd2;
  localparam logic [REG_AW-1:0] RA_CTRL = 3'd3;
  localparam logic [REG_AW-1:0] RA_MC   = 3'd4;

  // Effective source of one pin: a control bit of 1 overrides the static code.
  function automatic src_e pin_source(input logic ctrl_bit, input logic [1:0] code);
    if (ctrl_bit) return SRC_ADDR;
    return src_e'(code);
  endfunction

  function automatic logic pick_bit(input src_e src, input logic d_bit,
                                    input logic a_bit, input logic m_bit,
                                    input logic c_bit);
    logic r;
    case (src)
      SRC_DOUT:  r = d_bit;
      SRC_ADDR:  r = a_bit;
      SRC_MCELL: r = m_bit;
      default:   r = c_bit;
    endcase
    return r;
  endfunction

  function automatic logic drive_enable(input logic ext_mode, input logic dir_bit,
                                        input logic term_bit);
    return ext_mode ? term_bit : dir_bit;
  endfunction

endpackage

// File: rtl/mio_regs.sv
module mio_regs
  import mio_pkg::*;
#(
  parameter int W        = 8,
  parameter bit HAS_CTRL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      ctrl_q
);

  logic wr_dout, wr_dir, wr_ctrl, wr_void;

  assign wr_dout = wr_en && (reg_addr == RA_DOUT);
  assign wr_dir  = wr_en && (reg_addr == RA_DIR);
  assign wr_ctrl = wr_en && (reg_addr == RA_CTRL);
  assign wr_void = wr_en && !wr_dout && !wr_dir && !wr_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_dout) dout_q <= wr_data;
      if (wr_dir)  dir_q  <= wr_data;
    end
  end

  generate
    if (HAS_CTRL) begin : g_ctrl
      logic [W-1:0] ctrl_r;
      always_ff @(posedge clk) begin
        if (rst)          ctrl_r <= '0;
        else if (wr_ctrl) ctrl_r <= wr_data;
      end
      assign ctrl_q = ctrl_r;
    end else begin : g_noctrl
      assign ctrl_q = '0;
    end
  endgenerate

  AST_WR_LOADS: assert property (@(posedge clk) disable iff (rst)
    wr_dout |=> dout_q == $past(wr_data)); // R2

  AST_WR_VOID_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_void |=> $stable(dout_q) && $stable(dir_q) && $stable(ctrl_q)); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> dout_q == '0 && dir_q == '0 && ctrl_q == '0); // R1

endmodule

// File: rtl/mio_addr_latch.sv
module mio_addr_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ale,
  input  logic [W-1:0] bus_addr,
  output logic [W-1:0] addr_q
);

  always_latch begin
    if (ale) addr_q <= bus_addr;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ale && !$past(ale) |-> $stable(addr_q)); // R6

  AST_LATCH_PASS: assert property (@(posedge clk) disable iff (rst)
    ale |-> addr_q == bus_addr); // R6

endmodule

// File: rtl/mio_sync.sv
module mio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stg[0] == $past(din)); // R8

endmodule

// File: rtl/mio_pin_mux.sv
module mio_pin_mux
  import mio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   dout_q,
  input  logic [W-1:0]   dir_q,
  input  logic [W-1:0]   ctrl_q,
  input  logic [W-1:0]   addr_q,
  input  logic [W-1:0]   mc_out,
  input  logic [W-1:0]   cs_in,
  input  logic [W-1:0]   oe_pt,
  input  logic [2*W-1:0] cfg_sel,
  input  logic [W-1:0]   cfg_oe_ext,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe
);

  logic [W-1:0] src_bit;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      src_e sel;
      assign sel        = pin_source(ctrl_q[i], cfg_sel[2*i +: 2]);
      assign src_bit[i] = pick_bit(sel, dout_q[i], addr_q[i], mc_out[i], cs_in[i]);
      assign pin_oe[i]  = drive_enable(cfg_oe_ext[i], dir_q[i], oe_pt[i]);
      assign pin_out[i] = pin_oe[i] & src_bit[i];

      AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (rst)
        !cfg_oe_ext[i] |-> pin_oe[i] == dir_q[i]); // R7

      AST_OE_FROM_TERM: assert property (@(posedge clk) disable iff (rst)
        cfg_oe_ext[i] |-> pin_oe[i] == oe_pt[i]); // R7

      AST_CTRL_ADDR: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[i] && pin_oe[i] |-> pin_out[i] == addr_q[i]); // R5

      AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !pin_oe[i] |-> !pin_out[i]); // R10
    end
  endgenerate

endmodule

// File: rtl/mio_port.sv
module mio_port
  import mio_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit HAS_CTRL = 1'b1,
  parameter int SYNC_N   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         reg_addr,
  input  logic               wr_en,
  input  logic [WIDTH-1:0]   wr_data,
  output logic [WIDTH-1:0]   rd_data,
  input  logic               ale,
  input  logic [WIDTH-1:0]   bus_addr,
  input  logic [WIDTH-1:0]   mc_out,
  input  logic [WIDTH-1:0]   cs_in,
  input  logic [WIDTH-1:0]   oe_pt,
  input  logic [2*WIDTH-1:0] cfg_sel,
  input  logic [WIDTH-1:0]   cfg_oe_ext,
  input  logic [WIDTH-1:0]   pin_in,
  output logic [WIDTH-1:0]   pin_out,
  output logic [WIDTH-1:0]   pin_oe
);

  logic [WIDTH-1:0] dout_q, dir_q, ctrl_q, addr_q, pin_sync;

  mio_regs #(.W(WIDTH), .HAS_CTRL(HAS_CTRL)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .dout_q(dout_q), .dir_q(dir_q), .ctrl_q(ctrl_q)
  );

  mio_addr_latch #(.W(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .bus_addr(bus_addr), .addr_q(addr_q)
  );

  mio_sync #(.W(WIDTH), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(pin_sync)
  );

  mio_pin_mux #(.W(WIDTH)) u_mux (
    .clk(clk), .rst(rst), .dout_q(dout_q), .dir_q(dir_q), .ctrl_q(ctrl_q),
    .addr_q(addr_q), .mc_out(mc_out), .cs_in(cs_in), .oe_pt(oe_pt),
    .cfg_sel(cfg_sel), .cfg_oe_ext(cfg_oe_ext), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    case (reg_addr)
      RA_PIN:  rd_data = pin_sync;
      RA_DOUT: rd_data = dout_q;
      RA_DIR:  rd_data = dir_q;
      RA_CTRL: rd_data = ctrl_q;
      RA_MC:   rd_data = mc_out;
      default: rd_data = '0;
    endcase
  end

  AST_MC_READ: assert property (@(posedge clk) disable iff (rst)
    reg_addr == RA_MC |-> rd_data == mc_out); // R9

  AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_addr > RA_MC |-> rd_data == '0); // R9

endmodule

// File: tb/mio_port_bench.sv
module mio_port_bench;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [2:0]     reg_addr = '0;
  logic           wr_en = 1'b0;
  logic [W-1:0]   wr_data = '0;
  logic [W-1:0]   rd_data;
  logic           ale = 1'b1;
  logic [W-1:0]   bus_addr = '0;
  logic [W-1:0]   mc_out = '0;
  logic [W-1:0]   cs_in = '0;
  logic [W-1:0]   oe_pt = '0;
  logic [2*W-1:0] cfg_sel = '0;
  logic [W-1:0]   cfg_oe_ext = '0;
  logic [W-1:0]   pin_in = '0;
  logic [W-1:0]   pin_out;
  logic [W-1:0]   pin_oe;

  int n_run = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mio_port u_mio_port (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ale(ale), .bus_addr(bus_addr), .mc_out(mc_out),
    .cs_in(cs_in), .oe_pt(oe_pt), .cfg_sel(cfg_sel), .cfg_oe_ext(cfg_oe_ext),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Bench model of the register state, kept from the requirements.
  logic [W-1:0] m_dout = '0, m_dir = '0, m_ctrl = '0, m_addr = '0;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd1: m_dout = d;
      3'd2: m_dir  = d;
      3'd3: m_ctrl = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    reg_addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic logic [W-1:0] exp_oe();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = cfg_oe_ext[i] ? oe_pt[i] : m_dir[i];
    return r;
  endfunction

  function automatic logic [W-1:0] exp_out();
    logic [W-1:0] r;
    logic [W-1:0] en;
    en = exp_oe();
    for (int i = 0; i < W; i++) begin
      int code;
      code = m_ctrl[i] ? 1 : int'(cfg_sel[2*i +: 2]);
      if (code == 0)      r[i] = m_dout[i];
      else if (code == 1) r[i] = m_addr[i];
      else if (code == 2) r[i] = mc_out[i];
      else                r[i] = cs_in[i];
      r[i] = r[i] & en[i];
    end
    return r;
  endfunction

  task automatic check_pins(input string req);
    #1;
    check(req, pin_oe, exp_oe());
    check(req, pin_out, exp_out());
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A; pats[3] = 8'hC3;

    // Preset register contents before reset, so that R1 shows a clear.
    rst = 1'b0;
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); rst = 1'b1;
    m_dout = '0; m_dir = '0; m_ctrl = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    bus_addr = 8'h00; m_addr = 8'h00;
    rd(3'd1, v); check("R1 dout", v, 8'h00);
    rd(3'd2, v); check("R1 dir", v, 8'h00);
    rd(3'd3, v); check("R1 ctrl", v, 8'h00);
    #1; check("R1 oe", pin_oe, 8'h00);

    // R2: write/read sweep on each writable register
    for (int a = 1; a <= 3; a++)
      for (int p = 0; p < 4; p++) begin
        wr(a[2:0], pats[p] ^ 8'(a));
        rd(a[2:0], v);
        check("R2 readback", v, pats[p] ^ 8'(a));
      end

    // R3: ignored addresses
    wr(3'd1, 8'h12); wr(3'd2, 8'h34); wr(3'd3, 8'h56);
    for (int a = 0; a < 8; a++)
      if (a == 0 || a >= 4) wr(a[2:0], 8'hA5);
    rd(3'd1, v); check("R3 dout", v, 8'h12);
    rd(3'd2, v); check("R3 dir", v, 8'h34);
    rd(3'd3, v); check("R3 ctrl", v, 8'h56);

    // R4: every source code on all pins, then mixed codes
    wr(3'd3, 8'h00); wr(3'd2, 8'hFF); wr(3'd1, 8'h96);
    bus_addr = 8'h3C; m_addr = 8'h3C;
    @(negedge clk); ale = 1'b0;
    mc_out = 8'hE1; cs_in = 8'h4B;
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < W; i++) cfg_sel[2*i +: 2] = c[1:0];
      check_pins("R4 uniform code");
    end
    for (int i = 0; i < W; i++) cfg_sel[2*i +: 2] = 2'(i % 4);
    check_pins("R4 mixed code");
    for (int i = 0; i < W; i++) cfg_sel[2*i +: 2] = 2'(3 - (i % 4));
    check_pins("R4 mixed reversed");

    // R5: control bits force the address source
    for (int i = 0; i < W; i++) cfg_sel[2*i +: 2] = 2'd2;
    wr(3'd3, 8'h0F);
    check_pins("R5 ctrl low nibble");
    #1; check("R5 forced bits", pin_out & 8'h0F, m_addr & 8'h0F);
    wr(3'd3, 8'hF0);
    check_pins("R5 ctrl high nibble");

    // R6: latch holds while ale low, follows while high
    wr(3'd3, 8'hFF);
    bus_addr = 8'hA7;
    check_pins("R6 hold");
    #1; check("R6 hold value", pin_out, 8'h3C);
    ale = 1'b1; m_addr = 8'hA7;
    check_pins("R6 transparent");
    @(negedge clk); ale = 1'b0;
    bus_addr = 8'h11;
    @(negedge clk);
    check_pins("R6 hold after close");

    // R7: enable mode per pin
    wr(3'd3, 8'h00); wr(3'd2, 8'h3C);
    cfg_oe_ext = 8'hF0; oe_pt = 8'hAA;
    #1; check("R7 mixed enable", pin_oe, 8'hA0 | 8'h0C);
    check_pins("R7 pins");
    oe_pt = 8'h55;
    check_pins("R7 term follows");

    // R10: disabled pins drive low
    cfg_oe_ext = 8'h00; mc_out = 8'hFF; cs_in = 8'hFF;
    wr(3'd1, 8'hFF); wr(3'd2, 8'h00);
    #1; check("R10 idle low", pin_out, 8'h00);

    // R8: two-edge synchronizer latency
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] prev;
      @(negedge clk);
      rd(3'd0, prev);
      pin_in = pats[p] ^ 8'h81;
      @(negedge clk);
      rd(3'd0, v); check("R8 one edge", v, prev);
      @(negedge clk);
      rd(3'd0, v); check("R8 two edges", v, pats[p] ^ 8'h81);
    end

    // R9: macrocell read and unused addresses
    mc_out = 8'h6D;
    rd(3'd4, v); check("R9 mc read", v, 8'h6D);
    mc_out = 8'h92;
    rd(3'd4, v); check("R9 mc live", v, 8'h92);
    for (int a = 5; a < 8; a++) begin
      rd(a[2:0], v); check("R9 zero", v, 8'h00);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule